// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block rotates a signed fixed-point vector (x, y) by a signed angle a. It uses a fully unrolled CORDIC pipeline in rotation mode. Each clock it accepts one new sample, and each clock it delivers one rotated vector (x0, y0) a fixed number of cycles later. A valid flag travels through the pipeline with the data. An optional enable input freezes every pipeline register.

x and y lie in [-1, 1] and carry F fraction bits in an F+2 bit two's-complement word. The angle is in radians and lies in [-π, +π]. It carries the same F fraction bits in an F+3 bit word. Angles outside ±π/2 are folded before the iterations start: the vector is negated and the residual angle is moved by π. FOUT+2 micro-rotations follow. The internal words carry three guard bits.

The elaboration option `COMP` selects between two output modes:
- With `COMP` = 0, the result is the plain similarity rotation x0 = K(x·cos a − y·sin a), y0 = K(x·sin a + y·cos a), with K ≈ 1.6467602. Each output is FOUT+3 bits wide with three integer bits.
- With `COMP` = 1, the output stage multiplies by a constant 1/K and then rounds. The result is the true rotation in FOUT+2 bits.

The latency is FOUT+4 cycles: one fold register, FOUT+2 iteration registers and one rounding register.

Top module: `cordic_rot`

## Requirements
- R1: With COMP=0, x_o and y_o equal round(2^FOUT·K·(x·cos a − y·sin a)) and round(2^FOUT·K·(x·sin a + y·cos a)) within ±3 LSB. Here x = x_i/2^F, y = y_i/2^F, a = a_i/2^F, K = 1.6467602, and the outputs are FOUT+3 bit two's complement.
- R2: With COMP=1, the outputs equal the same expressions without the factor K within ±3 LSB, as FOUT+2 bit two's complement.
- R3: Angles with |a| > π/2, up to the full ±π input range, give results as accurate as R1 and R2 require.
- R4: valid_o rises exactly FOUT+4 enabled clock cycles after valid_i is sampled high, and x_o and y_o hold the result for that sample in the same cycle.
- R5: While en_i is low (with HAS_EN=1), no pipeline register changes. valid_o, x_o and y_o hold, and a sample in flight is delayed by exactly the number of stalled cycles.
- R6: While rst_ni is low, valid_o, x_o and y_o are 0.
- R7: The extreme corner inputs x, y = ±1 never overflow. |x_o| and |y_o| stay within 2.33·2^FOUT (COMP=0) or 1.415·2^FOUT (COMP=1), plus a few LSB.
- R8: Samples presented on consecutive cycles come out on consecutive cycles, in order, each with its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pipeline enable (ignored when HAS_EN=0) |
| valid_i | input | 1 | Input sample valid |
| x_i | input | F+2 | x coordinate, signed, F fraction bits |
| y_i | input | F+2 | y coordinate, signed, F fraction bits |
| a_i | input | F+3 | Rotation angle in radians, signed, F fraction bits |
| valid_o | output | 1 | Output sample valid |
| x_o | output | FOUT+3 (COMP=0) / FOUT+2 (COMP=1) | Rotated x, signed, FOUT fraction bits |
| y_o | output | FOUT+3 (COMP=0) / FOUT+2 (COMP=1) | Rotated y, signed, FOUT fraction bits |

## Verification
The bench targets angles near ±π and just past ±π/2. A wrong fold would send those results to the mirrored quadrant or drive the iterations out of their convergence range, so the error would be large. The corner vectors x = y = ±1 rotated by ±π/4 drive one output to its peak of about 2.33. Too few integer bits would wrap that output to a value of the wrong sign. The bench also stalls the enable while a sample is in flight and runs back-to-back samples. A stage that ignores the enable would deliver the sample early, and a misordered pipeline would pair a result with the wrong input. Both instances are run side by side, so that a wrong or missing 1/K constant appears as a ratio of K between the two results.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  // constants in Q60
  localparam longint PI_Q60 = 64'sd3622009729038561421;

  function automatic longint inv_k_q60();
    return 64'sd700114967656000000;
  endfunction

  // arctan(2^-i) in Q60, series for i >= 1
  function automatic longint atan_q60(input int i);
    longint acc;
    longint term;
    acc = 0;
    if (i == 0) return PI_Q60 >>> 2;
    for (int k = 0; k < 32; k++) begin
      int sh;
      sh = i * (2 * k + 1);
      if (sh < 61) begin
        term = (64'sd1 <<< 60) >>> sh;
        term = term / longint'(2 * k + 1);
        acc = (k % 2 == 0) ? acc + term : acc - term;
      end
    end
    return acc;
  endfunction

  function automatic longint q60_round(input longint v, input int frac);
    return (v + (64'sd1 <<< (59 - frac))) >>> (60 - frac);
  endfunction
endpackage

// File: rtl/cordic_fold.sv
module cordic_fold import cordic_pkg::*; #(
  parameter int F   = 12,
  parameter int IF  = 15,
  parameter int AF  = 15,
  parameter int IW  = IF + 4,
  parameter int AWI = AF + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  valid_i,
  input  logic signed [F+1:0]   x_i,
  input  logic signed [F+1:0]   y_i,
  input  logic signed [F+2:0]   a_i,
  output logic                  valid_o,
  output logic signed [IW-1:0]  x_o,
  output logic signed [IW-1:0]  y_o,
  output logic signed [AWI-1:0] z_o
);
  localparam longint PI_L = q60_round(PI_Q60, AF);
  localparam longint HP_L = q60_round(PI_Q60 >>> 1, AF);
  localparam logic signed [AWI-1:0] PI_Q = PI_L[AWI-1:0];
  localparam logic signed [AWI-1:0] HP_Q = HP_L[AWI-1:0];

  logic signed [IW-1:0]  xe, ye, xn, yn;
  logic signed [AWI-1:0] ae, zn;

  always_comb begin
    xe = $signed({{2{x_i[F+1]}}, x_i, {(IF-F){1'b0}}});
    ye = $signed({{2{y_i[F+1]}}, y_i, {(IF-F){1'b0}}});
    ae = $signed({a_i[F+2], a_i, {(AF-F){1'b0}}});
    xn = xe;
    yn = ye;
    zn = ae;
    // rotation by pi is a negation of the vector
    if (ae > HP_Q) begin
      xn = -xe;
      yn = -ye;
      zn = ae - PI_Q;
    end else if (ae < -HP_Q) begin
      xn = -xe;
      yn = -ye;
      zn = ae + PI_Q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      x_o     <= xn;
      y_o     <= yn;
      z_o     <= zn;
    end
  end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage import cordic_pkg::*; #(
  parameter int IDX = 0,
  parameter int IW  = 19,
  parameter int AF  = 15,
  parameter int AWI = AF + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  valid_i,
  input  logic signed [IW-1:0]  x_i,
  input  logic signed [IW-1:0]  y_i,
  input  logic signed [AWI-1:0] z_i,
  output logic                  valid_o,
  output logic signed [IW-1:0]  x_o,
  output logic signed [IW-1:0]  y_o,
  output logic signed [AWI-1:0] z_o
);
  localparam longint ATAN_L = q60_round(atan_q60(IDX), AF);
  localparam logic signed [AWI-1:0] ATAN_Q = ATAN_L[AWI-1:0];

  logic signed [IW-1:0]  xs, ys, xn, yn;
  logic signed [AWI-1:0] zn;

  always_comb begin
    xs = x_i >>> IDX;
    ys = y_i >>> IDX;
    if (!z_i[AWI-1]) begin
      xn = x_i - ys;
      yn = y_i + xs;
      zn = z_i - ATAN_Q;
    end else begin
      xn = x_i + ys;
      yn = y_i - xs;
      zn = z_i + ATAN_Q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      x_o     <= xn;
      y_o     <= yn;
      z_o     <= zn;
    end
  end
endmodule

// File: rtl/cordic_out.sv
module cordic_out import cordic_pkg::*; #(
  parameter int IF   = 15,
  parameter int IW   = IF + 4,
  parameter int FOUT = 12,
  parameter bit COMP = 1'b0,
  parameter int OW   = FOUT + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 valid_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] x_o,
  output logic signed [OW-1:0] y_o
);
  localparam int SH = IF - FOUT;

  logic signed [OW-1:0] xr, yr;

  if (COMP) begin : g_comp
    localparam int CF = IF;
    localparam int PW = IW + CF + 2;
    localparam int SHC = CF + SH;
    localparam longint INVK_L = q60_round(inv_k_q60(), CF);
    localparam logic signed [CF+1:0] INVK = INVK_L[CF+1:0];
    localparam logic signed [PW-1:0] RND = {{(PW-1){1'b0}}, 1'b1} <<< (SHC - 1);
    logic signed [PW-1:0] kw, xw, yw, xp, yp;
    always_comb begin
      kw = $signed({{(PW-CF-2){1'b0}}, INVK});
      xw = $signed({{(PW-IW){x_i[IW-1]}}, x_i});
      yw = $signed({{(PW-IW){y_i[IW-1]}}, y_i});
      xp = xw * kw;
      yp = yw * kw;
      xr = OW'((xp + RND) >>> SHC);
      yr = OW'((yp + RND) >>> SHC);
    end
  end else begin : g_raw
    localparam logic signed [IW-1:0] RND = {{(IW-1){1'b0}}, 1'b1} <<< (SH - 1);
    always_comb begin
      xr = OW'((x_i + RND) >>> SH);
      yr = OW'((y_i + RND) >>> SH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      x_o     <= xr;
      y_o     <= yr;
    end
  end
endmodule

// File: rtl/cordic_rot.sv
module cordic_rot #(
  parameter int F      = 12,
  parameter int FOUT   = 12,
  parameter bit COMP   = 1'b0,
  parameter bit HAS_EN = 1'b1
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       en_i,
  input  logic                                       valid_i,
  input  logic signed [F+1:0]                        x_i,
  input  logic signed [F+1:0]                        y_i,
  input  logic signed [F+2:0]                        a_i,
  output logic                                       valid_o,
  output logic signed [(COMP ? FOUT+2 : FOUT+3)-1:0] x_o,
  output logic signed [(COMP ? FOUT+2 : FOUT+3)-1:0] y_o
);
  localparam int GB  = 3;
  localparam int MF  = (FOUT > F) ? FOUT : F;
  localparam int IF  = MF + GB;
  localparam int AF  = MF + GB;
  localparam int IW  = IF + 4;
  localparam int AWI = AF + 4;
  localparam int N   = FOUT + 2;
  localparam int OW  = COMP ? FOUT + 2 : FOUT + 3;
  localparam int LAT = N + 2;

  logic en;
  assign en = HAS_EN ? en_i : 1'b1;

  logic                  vs [N+1];
  logic signed [IW-1:0]  xs [N+1];
  logic signed [IW-1:0]  ys [N+1];
  logic signed [AWI-1:0] zs [N+1];

  cordic_fold #(.F(F), .IF(IF), .AF(AF), .IW(IW), .AWI(AWI)) u_fold (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .a_i(a_i),
    .valid_o(vs[0]), .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
  );

  for (genvar i = 0; i < N; i++) begin : g_iter
    cordic_stage #(.IDX(i), .IW(IW), .AF(AF), .AWI(AWI)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .valid_i(vs[i]),
      .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]),
      .valid_o(vs[i+1]), .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1])
    );
  end

  cordic_out #(.IF(IF), .IW(IW), .FOUT(FOUT), .COMP(COMP), .OW(OW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .valid_i(vs[N]),
    .x_i(xs[N]), .y_i(ys[N]),
    .valid_o(valid_o), .x_o(x_o), .y_o(y_o)
  );
endmodule

// File: rtl/cordic_rot_chk.sv
module cordic_rot_chk #(
  parameter int FOUT   = 12,
  parameter bit COMP   = 1'b0,
  parameter int LAT    = 16,
  parameter bit HAS_EN = 1'b1,
  parameter int OW     = FOUT + 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 valid_i,
  input logic                 valid_o,
  input logic signed [OW-1:0] x_o,
  input logic signed [OW-1:0] y_o
);
  localparam int BND = COMP ? ((1 << FOUT) * 1415) / 1000 + 8
                            : ((1 << FOUT) * 2330) / 1000 + 8;

  logic           en;
  logic [LAT-1:0] vpipe;
  assign en = HAS_EN ? en_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpipe <= '0;
    else if (en) vpipe <= {vpipe[LAT-2:0], valid_i};
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vpipe[LAT-1]);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(valid_o) && $stable(x_o) && $stable(y_o)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (x_o <= BND && x_o >= -BND && y_o <= BND && y_o >= -BND));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r6: assert (!valid_o && x_o == '0 && y_o == '0);
    end
  end
endmodule

bind cordic_rot cordic_rot_chk #(
  .FOUT(FOUT), .COMP(COMP), .LAT(LAT), .HAS_EN(HAS_EN), .OW(OW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
  .valid_o(valid_o), .x_o(x_o), .y_o(y_o)
);

// File: tb/cordic_rot_tb.sv
`timescale 1ns/1ps
module cordic_rot_tb;
  localparam int F    = 12;
  localparam int FOUT = 12;
  localparam int LAT  = FOUT + 4;
  localparam real K   = 1.6467602581;
  localparam real PI  = 3.14159265358979;
  localparam int TOL  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic en_i = 1'b1;
  logic valid_i = 1'b0;
  logic signed [F+1:0] x_i = '0;
  logic signed [F+1:0] y_i = '0;
  logic signed [F+2:0] a_i = '0;
  logic valid_u, valid_c;
  logic signed [FOUT+2:0] xu, yu;
  logic signed [FOUT+1:0] xc, yc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cordic_rot #(.F(F), .FOUT(FOUT), .COMP(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .a_i(a_i), .valid_o(valid_u), .x_o(xu), .y_o(yu));

  cordic_rot #(.F(F), .FOUT(FOUT), .COMP(1'b1)) u_dut_comp (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .a_i(a_i), .valid_o(valid_c), .x_o(xc), .y_o(yc));

  function automatic int qnt(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    int d;
    d = act - exp;
    checks++;
    if (d > tol || d < -tol) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(int xi, int yi, int ai);
    x_i = (F+2)'(xi);
    y_i = (F+2)'(yi);
    a_i = (F+3)'(ai);
  endtask

  // checks both instances against the rotation of (xi,yi) by ai
  task automatic chk_res(string req, int xi, int yi, int ai);
    real xq, yq, aq, rx, ry, s;
    xq = real'(xi) / (2.0 ** F);
    yq = real'(yi) / (2.0 ** F);
    aq = real'(ai) / (2.0 ** F);
    s  = 2.0 ** FOUT;
    rx = xq * $cos(aq) - yq * $sin(aq);
    ry = xq * $sin(aq) + yq * $cos(aq);
    chk({req, " x uncomp"}, int'(xu), qnt(K * rx * s), TOL);
    chk({req, " y uncomp"}, int'(yu), qnt(K * ry * s), TOL);
    chk({req, " x comp"}, int'(xc), qnt(rx * s), TOL);
    chk({req, " y comp"}, int'(yc), qnt(ry * s), TOL);
  endtask

  task automatic run_one(string req, real xr, real yr, real ar);
    int xi, yi, ai;
    xi = qnt(xr * 2.0 ** F);
    yi = qnt(yr * 2.0 ** F);
    ai = qnt(ar * 2.0 ** F);
    @(negedge clk);
    set_in(xi, yi, ai);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    chk({req, " valid early (R4)"}, int'(valid_u), 0, 0);
    @(negedge clk);
    chk({req, " valid at latency (R4)"}, int'(valid_u), 1, 0);
    chk({req, " comp valid (R4)"}, int'(valid_c), 1, 0);
    chk_res(req, xi, yi, ai);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 valid in reset", int'(valid_u), 0, 0);
    chk("R6 x in reset", int'(xu), 0, 0);
    chk("R6 y comp in reset", int'(yc), 0, 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_basic();
    run_one("R1 R2 zero angle", 0.5, 0.25, 0.0);
    run_one("R1 R2 pos angle", 0.75, -0.3, 0.6);
    run_one("R1 R2 neg angle", -0.4, 0.9, -1.2);
    run_one("R1 R2 near half pi", 0.2, 0.7, 1.5);
  endtask

  task automatic t_fold();
    run_one("R3 angle 2.5", 0.8, 0.1, 2.5);
    run_one("R3 angle -2.5", 0.3, -0.6, -2.5);
    run_one("R3 angle pi", 0.6, 0.4, PI);
    run_one("R3 angle -pi", -0.5, 0.7, -PI);
    run_one("R3 past half pi", 0.9, 0.0, 1.6);
  endtask

  task automatic t_extreme();
    run_one("R7 corner +pi/4", 1.0, 1.0, PI / 4.0);
    run_one("R7 corner -3pi/4", 1.0, 1.0, -3.0 * PI / 4.0);
    run_one("R7 corner neg", -1.0, -1.0, PI / 4.0);
    run_one("R7 corner mixed", 1.0, -1.0, -PI / 4.0);
  endtask

  task automatic t_stream();
    int xs [8];
    int ys [8];
    int as [8];
    for (int k = 0; k < 8; k++) begin
      xs[k] = qnt((0.9 - 0.2 * k) * 2.0 ** F);
      ys[k] = qnt((0.1 * k - 0.35) * 2.0 ** F);
      as[k] = qnt((-3.0 + 0.8 * k) * 2.0 ** F);
    end
    for (int c = 0; c < LAT + 8; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        chk("R8 stream valid", int'(valid_u), 1, 0);
        chk_res("R8 stream", xs[c-LAT], ys[c-LAT], as[c-LAT]);
      end
      if (c < 8) begin
        set_in(xs[c], ys[c], as[c]);
        valid_i = 1'b1;
      end else begin
        valid_i = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 stream ends", int'(valid_u), 0, 0);
  endtask

  task automatic t_enable();
    int xi, yi, ai, hx;
    xi = qnt(0.7 * 2.0 ** F);
    yi = qnt(-0.2 * 2.0 ** F);
    ai = qnt(2.2 * 2.0 ** F);
    @(negedge clk);
    set_in(xi, yi, ai);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    set_in(0, 0, 0);
    repeat (4) @(negedge clk);
    en_i = 1'b0;
    valid_i = 1'b1;  // must not enter while stalled
    repeat (3) @(negedge clk);
    valid_i = 1'b0;
    en_i = 1'b1;
    // 5 enabled edges so far; LAT-5 more needed, first valid at that count
    repeat (LAT - 6) @(negedge clk);
    chk("R5 stall delays valid", int'(valid_u), 0, 0);
    @(negedge clk);
    chk("R5 valid after stall", int'(valid_u), 1, 0);
    chk_res("R5 stalled sample", xi, yi, ai);
    hx = int'(xu);
    en_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 valid held", int'(valid_u), 1, 0);
    chk("R5 x held", int'(xu), hx, 0);
    en_i = 1'b1;
    @(negedge clk);
    chk("R5 no stray sample", int'(valid_u), 0, 0);
    repeat (LAT) @(negedge clk);
    chk("R5 stalled input ignored", int'(valid_u), 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_fold();
    t_extreme();
    t_stream();
    t_enable();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule